// File: doc/BRIEF.md
# Stack and Indirect-Control Group Unit

This unit executes the one-operand instruction group whose operation is picked by the 3-bit subop field of the addressing byte. Four operations exist: an indirect jump, which loads the instruction pointer from memory; a push of a memory word onto the stack; a pop from the stack into a memory word; and a bitwise complement of a memory word in place. An upstream decoder has already resolved the effective address. It hands the unit the opcode, the subop, that address and the instruction length. The unit owns the stack pointer and the instruction pointer. It reaches data memory through a word-wide, little-endian request port, with one request in flight at a time.

The command input is a valid/ready stream. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the cycle after the retire pulse, so the producer must hold a command until it transfers. The memory request side is also valid/ready: the unit holds address, write enable and write data steady while `mem_req_ready` is low. A write counts as complete on its handshake. A read response returns on `mem_rsp_valid` one or more cycles after the read handshake and cannot be back-pressured. `done_o` pulses once per command, with `illegal_o` alongside it.

Top module: `grp_unit`

## Requirements
- R1: After reset, `ip_o` equals RESET_IP, `sp_o` equals RESET_SP, `cmd_ready` is high and `mem_req_valid` is low.
- R2: Opcode 0xFF with subop 4 loads `ip_o` with the word read at the effective address, and `sp_o` is unchanged.
- R3: Opcode 0xFF with subop 6 reads the word at the effective address, then writes it at `sp_o` minus 4 and lowers `sp_o` by 4. The read happens before the stack pointer moves, so an effective address equal to the old `sp_o` yields the old top of stack.
- R4: Opcode 0x8F with subop 0 reads the word at `sp_o`, writes it to the effective address, and raises `sp_o` by 4.
- R5: Opcode 0xF7 with subop 2 replaces the word at the effective address with its bitwise complement, and `sp_o` is unchanged.
- R6: Any other opcode/subop pair retires with `illegal_o` high. It changes neither pointer and no memory.
- R7: Memory words are little-endian: the byte at address A is bits 7:0 of the word at A, and the byte at A+3 is bits 31:24.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, write enable and write data do not change.
- R9: No new memory request is issued while a read response is still outstanding.
- R10: `done_o` is a single-cycle pulse. `cmd_ready` is low during it and high in the following cycle. Every non-jump command that retires legally advances `ip_o` by `cmd_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_opcode | input | 8 | Primary opcode byte |
| cmd_subop | input | 3 | Subop field from the addressing byte |
| cmd_ea | input | XLEN | Resolved effective address |
| cmd_len | input | LW | Instruction length in bytes |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | XLEN | Byte address of the word |
| mem_req_wdata | output | XLEN | Little-endian write word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | XLEN | Little-endian read word |
| done_o | output | 1 | Retire pulse |
| illegal_o | output | 1 | Retired command was not a group member |
| ip_o | output | XLEN | Instruction pointer |
| sp_o | output | XLEN | Stack pointer |

## Verification
The bench runs pushes from a plain address and from an address equal to the current stack pointer. The second case tells whether the operand read happens before or after the pointer moves. A pop back into memory then returns the pushed value. Jumps through words whose four bytes all differ reveal any byte swap. A complement applied twice must restore the original word. Several illegal pairs are sent, covering a wrong subop under each group opcode and an opcode outside the group, and each must leave both pointers and the probed word untouched. The memory model stalls requests and varies read latency throughout, which exercises the request-hold and single-outstanding rules.

// File: rtl/grp_pkg.sv
package grp_pkg;
  localparam int OPW  = 8;
  localparam int SUBW = 3;

  localparam logic [OPW-1:0]  OPC_INDIRECT = 8'hFF;
  localparam logic [OPW-1:0]  OPC_POP_RM   = 8'h8F;
  localparam logic [OPW-1:0]  OPC_UNARY    = 8'hF7;

  localparam logic [SUBW-1:0] SUB_JUMP   = 3'd4;
  localparam logic [SUBW-1:0] SUB_PUSH   = 3'd6;
  localparam logic [SUBW-1:0] SUB_POP    = 3'd0;
  localparam logic [SUBW-1:0] SUB_INVERT = 3'd2;

  typedef enum logic [2:0] {
    OPK_JUMP, OPK_PUSH, OPK_POP, OPK_INVERT, OPK_BAD
  } opkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_FIN
  } state_e;
endpackage

// File: rtl/grp_decode.sv
module grp_decode
  import grp_pkg::*;
(
  input  logic [OPW-1:0]  opcode,
  input  logic [SUBW-1:0] subop,
  output opkind_e         kind
);
  always_comb begin
    kind = OPK_BAD;
    unique case (opcode)
      OPC_INDIRECT: begin
        if (subop == SUB_JUMP)      kind = OPK_JUMP;
        else if (subop == SUB_PUSH) kind = OPK_PUSH;
      end
      OPC_POP_RM: begin
        if (subop == SUB_POP) kind = OPK_POP;
      end
      OPC_UNARY: begin
        if (subop == SUB_INVERT) kind = OPK_INVERT;
      end
      default: kind = OPK_BAD;
    endcase
  end
endmodule

// File: rtl/grp_regs.sv
module grp_regs #(
  parameter int          XLEN     = 32,
  parameter int          LW       = 4,
  parameter logic [31:0] RESET_IP = 32'h1,
  parameter logic [31:0] RESET_SP = 32'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_dec,
  input  logic            sp_inc,
  input  logic            ip_load,
  input  logic [XLEN-1:0] ip_load_val,
  input  logic            ip_adv,
  input  logic [LW-1:0]   adv_len,
  output logic [XLEN-1:0] sp,
  output logic [XLEN-1:0] ip,
  output logic [XLEN-1:0] sp_below
);
  localparam int              WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_BYTES);

  assign sp_below = sp - STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= XLEN'(RESET_SP);
    end else if (sp_dec) begin
      sp <= sp_below;
    end else if (sp_inc) begin
      sp <= sp + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip <= XLEN'(RESET_IP);
    end else if (ip_load) begin
      ip <= ip_load_val;
    end else if (ip_adv) begin
      ip <= ip + {{(XLEN-LW){1'b0}}, adv_len};
    end
  end
endmodule

// File: rtl/grp_ctrl.sv
module grp_ctrl
  import grp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  opkind_e         kind,
  input  logic [XLEN-1:0] cmd_ea,
  input  logic [LW-1:0]   cmd_len,
  input  logic [XLEN-1:0] sp,
  input  logic [XLEN-1:0] sp_below,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            sp_dec,
  output logic            sp_inc,
  output logic            ip_load,
  output logic [XLEN-1:0] ip_load_val,
  output logic            ip_adv,
  output logic [LW-1:0]   adv_len,
  output logic            done,
  output logic            illegal
);
  state_e          st_q;
  opkind_e         kind_q;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] data_q;
  logic [LW-1:0]   len_q;
  logic            bad_q;
  logic            cmd_fire;
  logic            wr_fire;

  assign cmd_ready = (st_q == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign wr_fire   = (st_q == ST_WR_REQ) && mem_req_ready;
  assign done      = (st_q == ST_FIN);
  assign illegal   = done && bad_q;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = ea_q;
    mem_req_wdata = (kind_q == OPK_INVERT) ? ~data_q : data_q;
    if (st_q == ST_RD_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = (kind_q == OPK_POP) ? sp : ea_q;
    end else if (st_q == ST_WR_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_we    = 1'b1;
      mem_req_addr  = (kind_q == OPK_PUSH) ? sp_below : ea_q;
    end
  end

  assign ip_load     = (st_q == ST_RD_WAIT) && mem_rsp_valid && (kind_q == OPK_JUMP);
  assign ip_load_val = mem_rsp_data;
  assign sp_dec      = wr_fire && (kind_q == OPK_PUSH);
  assign sp_inc      = wr_fire && (kind_q == OPK_POP);
  assign ip_adv      = wr_fire;
  assign adv_len     = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= OPK_BAD;
      ea_q   <= '0;
      data_q <= '0;
      len_q  <= '0;
      bad_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            kind_q <= kind;
            ea_q   <= cmd_ea;
            len_q  <= cmd_len;
            bad_q  <= (kind == OPK_BAD);
            st_q   <= (kind == OPK_BAD) ? ST_FIN : ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (mem_req_ready) st_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            st_q   <= (kind_q == OPK_JUMP) ? ST_FIN : ST_WR_REQ;
          end
        end
        ST_WR_REQ: begin
          if (mem_req_ready) st_q <= ST_FIN;
        end
        ST_FIN: begin
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/grp_unit.sv
module grp_unit
  import grp_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LW       = 4,
  parameter logic [31:0] RESET_IP = 32'h1,
  parameter logic [31:0] RESET_SP = 32'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [7:0]      cmd_opcode,
  input  logic [2:0]      cmd_subop,
  input  logic [XLEN-1:0] cmd_ea,
  input  logic [LW-1:0]   cmd_len,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            done_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] ip_o,
  output logic [XLEN-1:0] sp_o
);
  opkind_e         kind;
  logic            sp_dec, sp_inc, ip_load, ip_adv;
  logic [XLEN-1:0] ip_load_val, sp_below;
  logic [LW-1:0]   adv_len;

  grp_decode u_dec (
    .opcode (cmd_opcode),
    .subop  (cmd_subop),
    .kind   (kind)
  );

  grp_regs #(
    .XLEN(XLEN), .LW(LW), .RESET_IP(RESET_IP), .RESET_SP(RESET_SP)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sp_dec      (sp_dec),
    .sp_inc      (sp_inc),
    .ip_load     (ip_load),
    .ip_load_val (ip_load_val),
    .ip_adv      (ip_adv),
    .adv_len     (adv_len),
    .sp          (sp_o),
    .ip          (ip_o),
    .sp_below    (sp_below)
  );

  grp_ctrl #(.XLEN(XLEN), .LW(LW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .kind          (kind),
    .cmd_ea        (cmd_ea),
    .cmd_len       (cmd_len),
    .sp            (sp_o),
    .sp_below      (sp_below),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .sp_dec        (sp_dec),
    .sp_inc        (sp_inc),
    .ip_load       (ip_load),
    .ip_load_val   (ip_load_val),
    .ip_adv        (ip_adv),
    .adv_len       (adv_len),
    .done          (done_o),
    .illegal       (illegal_o)
  );
endmodule

// File: rtl/grp_unit_chk.sv
module grp_unit_chk #(
  parameter int XLEN = 32,
  parameter int LW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [7:0]      cmd_opcode,
  input logic [2:0]      cmd_subop,
  input logic [XLEN-1:0] cmd_ea,
  input logic [LW-1:0]   cmd_len,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [XLEN-1:0] mem_req_addr,
  input logic [XLEN-1:0] mem_req_wdata,
  input logic            mem_rsp_valid,
  input logic [XLEN-1:0] mem_rsp_data,
  input logic            done_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] ip_o,
  input logic [XLEN-1:0] sp_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  logic rd_pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      rd_pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_pend <= 1'b1;
    else if (mem_rsp_valid)                          rd_pend <= 1'b0;
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req_valid);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && cmd_ready);

  a_r10_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_ready);

  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> done_o && $stable(sp_o) && $stable(ip_o));

  a_r3_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_o) |-> done_o && (sp_o == $past(sp_o) - STEP || sp_o == $past(sp_o) + STEP));

  a_r2_ip_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ip_o) |-> done_o && !illegal_o);
endmodule

bind grp_unit grp_unit_chk #(.XLEN(XLEN), .LW(LW)) u_chk (.*);

// File: tb/test_grp_unit.sv
module test_grp_unit;
  localparam int XLEN = 32;
  localparam int LW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [7:0]      cmd_opcode = '0;
  logic [2:0]      cmd_subop = '0;
  logic [XLEN-1:0] cmd_ea = '0;
  logic [LW-1:0]   cmd_len = '0;
  logic            mem_req_valid, mem_req_we;
  logic            mem_req_ready = 1'b0;
  logic [XLEN-1:0] mem_req_addr, mem_req_wdata;
  logic            mem_rsp_valid = 1'b0;
  logic [XLEN-1:0] mem_rsp_data = '0;
  logic            done_o, illegal_o;
  logic [XLEN-1:0] ip_o, sp_o;

  always #10 clk = ~clk;

  grp_unit i_grp_unit (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // ---------------- memory model (sole writer of mem) ----------------
  logic [7:0]  mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_addr = '0;
  logic [31:0] poke_word = '0;
  logic [7:0]  lf = 8'hA5;
  int          pend = 0;
  logic [31:0] pdata = '0;

  function automatic logic [31:0] rd_word(input logic [7:0] a);
    return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[a]};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend > 0) begin
      if (pend == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pdata;
      end
      pend <= pend - 1;
    end
    if (poke_en) begin
      for (int i = 0; i < 4; i++) mem[8'(poke_addr + 8'(i))] <= poke_word[8*i +: 8];
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        for (int i = 0; i < 4; i++) mem[8'(mem_req_addr[7:0] + 8'(i))] <= mem_req_wdata[8*i +: 8];
      end else begin
        pend  <= 1 + int'(lf[0]) + int'(lf[3]);
        pdata <= rd_word(mem_req_addr[7:0]);
      end
    end
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_req_ready <= lf[1] | lf[2];
  end

  task automatic poke(input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_word = w;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] ip;
    logic [31:0] sp;
    logic        ill;
    logic [7:0]  addr;
    logic [31:0] word;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_ip = 32'h1;
  logic [31:0] m_sp = 32'h80;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      exp_t e;
      if (q.size() == 0) begin
        check(1'b0, "R10", "unexpected retire", 32'h1, 32'h0);
      end else begin
        e = q.pop_front();
        check(ip_o == e.ip, e.tag, "ip", ip_o, e.ip);
        check(sp_o == e.sp, e.tag, "sp", sp_o, e.sp);
        check(illegal_o == e.ill, e.tag, "illegal", 32'(illegal_o), 32'(e.ill));
        check(rd_word(e.addr) == e.word, e.tag, "memory word", rd_word(e.addr), e.word);
        check(cmd_ready == 1'b0, "R10", "ready during retire", 32'(cmd_ready), 32'h0);
      end
    end
  end

  // driver: computes the expected result from the requirements, then drives
  task automatic issue(input logic [7:0] op, input logic [2:0] sub,
                       input logic [7:0] ea, input logic [3:0] len, input string tag);
    exp_t e;
    logic [31:0] w;
    e.tag = tag; e.ill = 1'b0; e.addr = ea; e.word = rd_word(ea);
    if (op == 8'hFF && sub == 3'd4) begin
      m_ip = rd_word(ea);
    end else if (op == 8'hFF && sub == 3'd6) begin
      w = rd_word(ea);
      m_sp = m_sp - 4;
      m_ip = m_ip + 32'(len);
      e.addr = m_sp[7:0]; e.word = w;
    end else if (op == 8'h8F && sub == 3'd0) begin
      w = rd_word(m_sp[7:0]);
      m_sp = m_sp + 4;
      m_ip = m_ip + 32'(len);
      e.word = w;
    end else if (op == 8'hF7 && sub == 3'd2) begin
      e.word = ~rd_word(ea);
      m_ip = m_ip + 32'(len);
    end else begin
      e.ill = 1'b1;
    end
    e.ip = m_ip; e.sp = m_sp;
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_subop = sub;
    cmd_ea = {24'h0, ea}; cmd_len = len;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10", "ready after retire", 32'(cmd_ready), 32'h1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ip_o == 32'h1, "R1", "reset ip", ip_o, 32'h1);
    check(sp_o == 32'h80, "R1", "reset sp", sp_o, 32'h80);
    check(cmd_ready == 1'b1, "R1", "reset ready", 32'(cmd_ready), 32'h1);
    check(mem_req_valid == 1'b0, "R1", "reset request", 32'(mem_req_valid), 32'h0);
    rst_n = 1'b1;
    poke(8'h60, 32'h0000_00af);
    poke(8'h40, 32'h0f0f_00ff);
    poke(8'h20, 32'h4433_2211);
    poke(8'h30, 32'h0000_0008);

    issue(8'hFF, 3'd6, 8'h60, 4'd2, "R3");        // push plain word
    issue(8'hFF, 3'd6, 8'h7c, 4'd3, "R3_oldsp");  // operand at the old top of stack
    issue(8'h8F, 3'd0, 8'h50, 4'd2, "R4");        // pop into memory
    issue(8'hF7, 3'd2, 8'h40, 4'd2, "R5");        // complement
    check(mem[8'h40] == 8'h00, "R7", "low byte after complement", 32'(mem[8'h40]), 32'h0);
    check(mem[8'h43] == 8'hf0, "R7", "high byte after complement", 32'(mem[8'h43]), 32'hf0);
    issue(8'hF7, 3'd2, 8'h40, 4'd6, "R5_twice");  // restores
    issue(8'hFF, 3'd4, 8'h20, 4'd2, "R2_R7");     // ip <- 0x44332211
    issue(8'hFF, 3'd4, 8'h30, 4'd2, "R2");        // ip <- 8
    issue(8'hFF, 3'd0, 8'h40, 4'd2, "R6");
    issue(8'hFF, 3'd7, 8'h40, 4'd2, "R6");
    issue(8'h8F, 3'd1, 8'h40, 4'd2, "R6");
    issue(8'hF7, 3'd3, 8'h40, 4'd2, "R6");
    issue(8'h01, 3'd0, 8'h40, 4'd2, "R6");
    issue(8'h8F, 3'd0, 8'h54, 4'd1, "R4_R10");    // pop back to reset sp
    check(sp_o == 32'h80, "R4", "stack balanced", sp_o, 32'h80);
    finish_run();
  end
endmodule